// File: doc/BRIEF.md
# Block-Mode DMA Transfer Sequencer

This block sequences one DMA channel that runs in block transfer mode. Software-side logic outside the block presents a configuration and pulses `arm`. The configuration holds a source start address, a destination start address, a step mode for each side, the unit size (byte or word), the side that is the block area, the block size M and the block count N. After arming, each transfer request accepted between blocks moves one whole block of M units. Each unit is a read from the source address followed by a write of the captured data to the destination address. Each phase of the bus-master interface is held until the bus returns ready.

Each address steps on its own after every unit. It can go up, go down or stay where it is, by 1 for bytes and by 2 for words, and it wraps modulo 2^24. The block-area side returns to its start address at the end of every block, so the same area is covered again by the next block. The other side keeps running. An inner counter, reloaded from a held copy of M, marks the end of each block. An outer counter ends the whole transfer after N blocks. At that point a one-cycle `done` pulse is raised and the channel goes idle until it is armed again.

Top module: `blk_dma_seq`

## Requirements
- R1: After reset `bus_valid` and `done` are 0 and the channel is idle; `xfer_req` has no effect until the channel is armed.
- R2: A pulse on `arm` while idle captures the whole configuration. After that, each `xfer_req` sampled high while the channel waits between blocks starts exactly one block of M units. No bus activity follows the block until another request is sampled.
- R3: Each unit is a read phase (`bus_valid`=1, `bus_wr`=0, source address) and then a write phase (`bus_wr`=1, destination address) whose `bus_wdata` equals the `bus_rdata` accepted in the read. Each phase holds its address and direction until `bus_ready` is sampled high.
- R4: Step mode encoding per side: 2'b01 adds the step after each unit, 2'b10 subtracts it, and 2'b00 and 2'b11 leave the address unchanged. The step is 2 when `cfg_word`=1 and 1 when `cfg_word`=0. `bus_word` shows the captured `cfg_word`.
- R5: Address stepping wraps modulo 2^24 in both directions.
- R6: With `cfg_blk_on_dst`=1 the destination address returns to its start value after each block while the source keeps stepping. With `cfg_blk_on_dst`=0 the source returns and the destination keeps stepping.
- R7: A block size of 0 means 256 units per block; values 1 to 255 mean that many units.
- R8: The transfer ends after N blocks, where a block count of 0 means 2^BCNT_W blocks (65,536 at the default width).
- R9: `done` is high for exactly one cycle, the cycle after the final write is accepted, with the channel idle. After it, `xfer_req` starts nothing until the next `arm`.
- R10: `xfer_req` and `arm` asserted while a block is in progress have no effect. No extra block is remembered, and the addresses and counts in use are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Pulse to capture the configuration and arm an idle channel |
| cfg_src_addr | input | ADDR_W | Source start address |
| cfg_dst_addr | input | ADDR_W | Destination start address |
| cfg_src_mode | input | 2 | Source step mode (01 up, 10 down, 00/11 hold) |
| cfg_dst_mode | input | 2 | Destination step mode (01 up, 10 down, 00/11 hold) |
| cfg_word | input | 1 | 1 for word units, 0 for byte units |
| cfg_blk_on_dst | input | 1 | 1 makes the destination the block area, 0 the source |
| cfg_blk_size | input | BSIZE_W | Units per block, 0 meaning 2^BSIZE_W |
| cfg_blk_count | input | BCNT_W | Blocks per transfer, 0 meaning 2^BCNT_W |
| xfer_req | input | 1 | Transfer request, sampled only between blocks |
| bus_valid | output | 1 | Bus phase active |
| bus_wr | output | 1 | 1 for write phase, 0 for read phase |
| bus_word | output | 1 | Unit size of the phase, 1 for word |
| bus_addr | output | ADDR_W | Address of the current phase |
| bus_wdata | output | DATA_W | Write data, the value read in the same unit |
| bus_rdata | input | DATA_W | Read data, taken when the read phase is ready |
| bus_ready | input | 1 | Completes the current phase |
| done | output | 1 | One-cycle pulse when the last block completes |

## Verification
A wrong address register shows on `bus_addr` at the next read or write phase. A step error or a missed block-area return is therefore visible within one unit, and the bench compares every phase address with a model built from the step rules. A wrong inner or outer count shows as a block that is too long or too short, or as a `done` pulse in the wrong block. This is seen at the end of the affected block, where the bench expects the bus to go quiet and `done` to match the block index. A lost or extra request shows as bus activity, or its absence, in the idle gaps that the bench watches between blocks and after `done`.

// File: rtl/blk_dma_pkg.sv
// Package: shared encodings for the block-mode DMA sequencer.
// Assumes: step mode is a 2-bit field decoded identically on both sides.
package blk_dma_pkg;

    // Per-side address step selection
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'b00,
        STEP_UP    = 2'b01,
        STEP_DOWN  = 2'b10,
        STEP_HOLD2 = 2'b11
    } step_mode_e;

    // Sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_WAIT = 2'b01,
        SEQ_RD   = 2'b10,
        SEQ_WR   = 2'b11
    } seq_state_e;

    // Side indices for the address generator array
    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/blk_dma_addr_gen.sv
// Module: one address register of the channel (source or destination).
// Loads its start address on arm, steps after each completed unit by the
// unit size in the selected direction, and returns to the start address at
// the end of a block when this side is the block area.
// Assumes: load, unit_done and blk_end are single-cycle strobes from the
// sequencer; blk_end is only asserted together with unit_done.
module blk_dma_addr_gen
    import blk_dma_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_in,
    input  logic [1:0]        mode_in,
    input  logic              word,
    input  logic              unit_done,
    input  logic              blk_end,
    input  logic              is_blk_area,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);

    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] cur_q;
    step_mode_e        mode_q;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] next_addr;

    // Step size from the unit size
    always_comb begin
        step = word ? STEP_WORD : STEP_BYTE;
    end

    // Next address after a unit, wrapping modulo 2^ADDR_W
    always_comb begin
        unique case (mode_q)
            STEP_UP:   next_addr = cur_q + step;
            STEP_DOWN: next_addr = cur_q - step;
            default:   next_addr = cur_q;
        endcase
    end

    // Start address and mode capture on arm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            mode_q  <= STEP_HOLD;
        end else if (load) begin
            start_q <= start_in;
            mode_q  <= step_mode_e'(mode_in);
        end
    end

    // Running address: load, step, or block-area return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (load) begin
            cur_q <= start_in;
        end else if (unit_done) begin
            if (blk_end && is_blk_area) begin
                cur_q <= start_q;
            end else begin
                cur_q <= next_addr;
            end
        end
    end

    assign addr = cur_q;

endmodule

// File: rtl/blk_dma_count.sv
// Module: block-size hold register, inner unit counter and outer block
// counter. A loaded zero in either counter stands for its full range.
// The inner counter reloads from the hold value when it runs out.
// Assumes: load, unit_done and blk_end are single-cycle strobes.
module blk_dma_count #(
    parameter int BSIZE_W = 8,
    parameter int BCNT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BSIZE_W-1:0] size_in,
    input  logic [BCNT_W-1:0]  count_in,
    input  logic               unit_done,
    input  logic               blk_end,
    output logic               last_unit,
    output logic               last_block
);

    localparam logic [BSIZE_W-1:0] UNIT_ONE  = BSIZE_W'(1);
    localparam logic [BCNT_W-1:0]  BLOCK_ONE = BCNT_W'(1);

    logic [BSIZE_W-1:0] hold_q;
    logic [BSIZE_W-1:0] unit_q;
    logic [BCNT_W-1:0]  block_q;

    // Hold register: written only on arm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= size_in;
        end
    end

    // Inner counter: counts units, reloads from hold when it reaches zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_q <= '0;
        end else if (load) begin
            unit_q <= size_in;
        end else if (unit_done) begin
            if (unit_q == UNIT_ONE) begin
                unit_q <= hold_q;
            end else begin
                unit_q <= unit_q - UNIT_ONE;
            end
        end
    end

    // Outer counter: counts completed blocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            block_q <= '0;
        end else if (load) begin
            block_q <= count_in;
        end else if (blk_end) begin
            block_q <= block_q - BLOCK_ONE;
        end
    end

    assign last_unit  = (unit_q == UNIT_ONE);
    assign last_block = (block_q == BLOCK_ONE);

endmodule

// File: rtl/blk_dma_ctrl.sv
// Module: channel sequencer. Waits for arm, then for a request between
// blocks, and runs read/write unit pairs until the counters report the
// end of the block and of the transfer. Raises a registered done pulse.
// Assumes: bus_ready completes the phase presented in the same cycle.
module blk_dma_ctrl
    import blk_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic xfer_req,
    input  logic bus_ready,
    input  logic last_unit,
    input  logic last_block,
    output logic load,
    output logic rd_take,
    output logic unit_done,
    output logic blk_end,
    output logic bus_valid,
    output logic bus_wr,
    output logic done
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       final_unit;

    // Strobes derived from the current state and bus handshake
    always_comb begin
        load       = (state_q == SEQ_IDLE) && arm;
        rd_take    = (state_q == SEQ_RD) && bus_ready;
        unit_done  = (state_q == SEQ_WR) && bus_ready;
        blk_end    = unit_done && last_unit;
        final_unit = blk_end && last_block;
        bus_valid  = (state_q == SEQ_RD) || (state_q == SEQ_WR);
        bus_wr     = (state_q == SEQ_WR);
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (arm)       state_d = SEQ_WAIT;
            SEQ_WAIT: if (xfer_req)  state_d = SEQ_RD;
            SEQ_RD:   if (bus_ready) state_d = SEQ_WR;
            SEQ_WR: begin
                if (bus_ready) begin
                    if (final_unit) begin
                        state_d = SEQ_IDLE;
                    end else if (last_unit) begin
                        state_d = SEQ_WAIT;
                    end else begin
                        state_d = SEQ_RD;
                    end
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Done pulse, registered one cycle after the final write is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= final_unit;
        end
    end

endmodule

// File: rtl/blk_dma_seq.sv
// Module: top of the block-mode DMA sequencer. Captures the configuration
// on arm, instantiates one address generator per side, the counters and
// the sequencer, and drives the read-then-write bus-master port.
// Assumes: configuration inputs are stable in the cycle arm is high.
module blk_dma_seq
    import blk_dma_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 16,
    parameter int BSIZE_W = 8,
    parameter int BCNT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [ADDR_W-1:0]  cfg_src_addr,
    input  logic [ADDR_W-1:0]  cfg_dst_addr,
    input  logic [1:0]         cfg_src_mode,
    input  logic [1:0]         cfg_dst_mode,
    input  logic               cfg_word,
    input  logic               cfg_blk_on_dst,
    input  logic [BSIZE_W-1:0] cfg_blk_size,
    input  logic [BCNT_W-1:0]  cfg_blk_count,
    input  logic               xfer_req,
    output logic               bus_valid,
    output logic               bus_wr,
    output logic               bus_word,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_ready,
    output logic               done
);

    logic              load;
    logic              rd_take;
    logic              unit_done;
    logic              blk_end;
    logic              last_unit;
    logic              last_block;
    logic              word_q;
    logic              blk_dst_q;
    logic [DATA_W-1:0] data_q;

    logic [ADDR_W-1:0] side_start [NUM_SIDES];
    logic [1:0]        side_mode  [NUM_SIDES];
    logic              side_blk   [NUM_SIDES];
    logic [ADDR_W-1:0] side_addr  [NUM_SIDES];

    // Per-side configuration routing
    always_comb begin
        side_start[SIDE_SRC] = cfg_src_addr;
        side_start[SIDE_DST] = cfg_dst_addr;
        side_mode[SIDE_SRC]  = cfg_src_mode;
        side_mode[SIDE_DST]  = cfg_dst_mode;
        side_blk[SIDE_SRC]   = !blk_dst_q;
        side_blk[SIDE_DST]   = blk_dst_q;
    end

    // Shared configuration capture on arm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= 1'b0;
            blk_dst_q <= 1'b0;
        end else if (load) begin
            word_q    <= cfg_word;
            blk_dst_q <= cfg_blk_on_dst;
        end
    end

    // Read data holding register between the two phases of a unit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_take) begin
            data_q <= bus_rdata;
        end
    end

    // One address generator per side
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        blk_dma_addr_gen #(
            .ADDR_W(ADDR_W)
        ) u_addr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .start_in   (side_start[s]),
            .mode_in    (side_mode[s]),
            .word       (word_q),
            .unit_done  (unit_done),
            .blk_end    (blk_end),
            .is_blk_area(side_blk[s]),
            .addr       (side_addr[s])
        );
    end

    blk_dma_count #(
        .BSIZE_W(BSIZE_W),
        .BCNT_W (BCNT_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .size_in   (cfg_blk_size),
        .count_in  (cfg_blk_count),
        .unit_done (unit_done),
        .blk_end   (blk_end),
        .last_unit (last_unit),
        .last_block(last_block)
    );

    blk_dma_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .xfer_req  (xfer_req),
        .bus_ready (bus_ready),
        .last_unit (last_unit),
        .last_block(last_block),
        .load      (load),
        .rd_take   (rd_take),
        .unit_done (unit_done),
        .blk_end   (blk_end),
        .bus_valid (bus_valid),
        .bus_wr    (bus_wr),
        .done      (done)
    );

    // Bus port drive: address follows the phase
    always_comb begin
        bus_addr  = bus_wr ? side_addr[SIDE_DST] : side_addr[SIDE_SRC];
        bus_word  = word_q;
        bus_wdata = data_q;
    end

endmodule

// File: rtl/blk_dma_seq_chk.sv
// Module: protocol checker for the block-mode DMA sequencer, bound to the
// top module. Observes ports only.
module blk_dma_seq_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic              done
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!bus_valid && !done)); // R1

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wr))); // R3

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_wr && bus_ready) |=> (bus_valid && bus_wr)); // R3

    AST_WRITE_CLOSES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_wr && bus_ready) |=> !(bus_valid && bus_wr)); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_valid); // R9

endmodule

bind blk_dma_seq blk_dma_seq_chk #(
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_ready(bus_ready),
    .done     (done)
);

// File: tb/blk_dma_seq_test.sv
module blk_dma_seq_test;

    localparam int AW = 24;
    localparam int DW = 16;
    localparam int SW = 8;
    localparam int CW = 10;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [1:0]    smode;
        logic [1:0]    dmode;
        logic          word;
        logic          blkdst;
        logic [SW-1:0] bsize;
        logic [CW-1:0] bcount;
        logic          wstate;
        logic          mid;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{24'h001000, 24'h200000, 2'b01, 2'b01, 1'b0, 1'b1, 8'd4, 10'd3, 1'b0, 1'b0},
        '{24'h100010, 24'h300000, 2'b10, 2'b00, 1'b1, 1'b0, 8'd3, 10'd2, 1'b1, 1'b0},
        '{24'hFFFFFE, 24'h000001, 2'b01, 2'b10, 1'b1, 1'b1, 8'd2, 10'd2, 1'b0, 1'b0},
        '{24'h040000, 24'h050000, 2'b01, 2'b01, 1'b0, 1'b1, 8'd0, 10'd1, 1'b0, 1'b0},
        '{24'h060000, 24'h070000, 2'b11, 2'b01, 1'b0, 1'b0, 8'd2, 10'd3, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [AW-1:0] cfg_src_addr = '0;
    logic [AW-1:0] cfg_dst_addr = '0;
    logic [1:0]    cfg_src_mode = '0;
    logic [1:0]    cfg_dst_mode = '0;
    logic          cfg_word = 1'b0;
    logic          cfg_blk_on_dst = 1'b0;
    logic [SW-1:0] cfg_blk_size = '0;
    logic [CW-1:0] cfg_blk_count = '0;
    logic          xfer_req = 1'b0;
    logic          bus_valid;
    logic          bus_wr;
    logic          bus_word;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready = 1'b0;
    logic          done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    blk_dma_seq #(
        .ADDR_W(AW), .DATA_W(DW), .BSIZE_W(SW), .BCNT_W(CW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_word(cfg_word), .cfg_blk_on_dst(cfg_blk_on_dst),
        .cfg_blk_size(cfg_blk_size), .cfg_blk_count(cfg_blk_count),
        .xfer_req(xfer_req), .bus_valid(bus_valid), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .done(done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Step model from R4/R5: 01 up, 10 down, else hold; modulo 2^24
    function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic [1:0] m,
                                                input logic w);
        logic [AW-1:0] s;
        s = w ? AW'(2) : AW'(1);
        if (m == 2'b01) return a + s;
        if (m == 2'b10) return a - s;
        return a;
    endfunction

    task automatic run_xfer(input vec_t v);
        logic [AW-1:0] src_e;
        logic [AW-1:0] dst_e;
        int units;
        int blocks;
        logic [DW-1:0] pat;
        cfg_src_addr = v.src;  cfg_dst_addr = v.dst;
        cfg_src_mode = v.smode; cfg_dst_mode = v.dmode;
        cfg_word = v.word; cfg_blk_on_dst = v.blkdst;
        cfg_blk_size = v.bsize; cfg_blk_count = v.bcount;
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        check("R2 armed channel idle before request", 32'(bus_valid), 32'd0);
        src_e = v.src; dst_e = v.dst;
        units  = (v.bsize == 0) ? 256 : int'(v.bsize);            // R7
        blocks = (v.bcount == 0) ? (1 << CW) : int'(v.bcount);    // R8
        for (int b = 0; b < blocks; b++) begin
            @(negedge clk); xfer_req = 1'b1;
            @(negedge clk); xfer_req = 1'b0;
            for (int u = 0; u < units; u++) begin
                pat = DW'(b * 37 + u * 5 + 16'h0A01);
                check("R3 read phase valid", 32'({bus_valid, bus_wr}), 32'b10);
                check("R4 R5 source address", 32'(bus_addr), 32'(src_e));
                check("R4 unit size", 32'(bus_word), 32'(v.word));
                if (v.wstate) begin
                    @(negedge clk);
                    check("R3 read held without ready", 32'({bus_valid, bus_wr, bus_addr}),
                          32'({2'b10, src_e}));
                end
                bus_ready = 1'b1; bus_rdata = pat;
                if (v.mid && b == 0 && u == 0) begin
                    xfer_req = 1'b1; arm = 1'b1;
                    cfg_src_addr = v.src ^ 24'h0F0F0F; cfg_blk_size = 8'd9;
                end
                @(negedge clk);
                bus_ready = 1'b0; xfer_req = 1'b0; arm = 1'b0;
                cfg_src_addr = v.src; cfg_blk_size = v.bsize;
                check("R3 write phase valid", 32'({bus_valid, bus_wr}), 32'b11);
                check("R4 R5 destination address", 32'(bus_addr), 32'(dst_e));
                check("R3 write data", 32'(bus_wdata), 32'(pat));
                if (v.wstate) begin
                    @(negedge clk);
                    check("R3 write held without ready", 32'({bus_valid, bus_wr, bus_addr}),
                          32'({2'b11, dst_e}));
                end
                bus_ready = 1'b1;
                @(negedge clk);
                bus_ready = 1'b0;
                src_e = step_addr(src_e, v.smode, v.word);
                dst_e = step_addr(dst_e, v.dmode, v.word);
            end
            // R6: block-area side returns to its start
            if (v.blkdst) dst_e = v.dst; else src_e = v.src;
            check("R8 done only after last block", 32'(done), 32'(b == blocks - 1));
            check("R2 no bus activity after block", 32'(bus_valid), 32'd0);
            if (v.mid && b == 0) begin
                repeat (3) @(negedge clk);
                check("R10 mid-block request not remembered", 32'(bus_valid), 32'd0);
            end
        end
        @(negedge clk);
        check("R9 done lasts one cycle", 32'(done), 32'd0);
        xfer_req = 1'b1;
        @(negedge clk); xfer_req = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 request after done ignored", 32'({bus_valid, done}), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset bus idle", 32'(bus_valid), 32'd0);
        check("R1 reset done low", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        xfer_req = 1'b1;
        @(negedge clk); xfer_req = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 request before arm ignored", 32'(bus_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_xfer(VECS[i]);
        end

        // R8: block count 0 means 2^CW blocks
        run_xfer('{24'h080000, 24'h090000, 2'b01, 2'b01, 1'b0, 1'b1, 8'd1, 10'd0, 1'b0, 1'b0});

        // R1: reset in the middle of a block returns the port to idle
        run_mid_reset();

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic run_mid_reset();
        cfg_src_addr = 24'h0A0000; cfg_dst_addr = 24'h0B0000;
        cfg_src_mode = 2'b01; cfg_dst_mode = 2'b01; cfg_word = 1'b0;
        cfg_blk_on_dst = 1'b0; cfg_blk_size = 8'd5; cfg_blk_count = 10'd2;
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0; xfer_req = 1'b1;
        @(negedge clk); xfer_req = 1'b0;
        check("R1 block started before reset", 32'(bus_valid), 32'd1);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset clears bus", 32'({bus_valid, done}), 32'd0);
        xfer_req = 1'b1;
        @(negedge clk); xfer_req = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset leaves channel unarmed", 32'(bus_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule